// File: doc/BRIEF.md
# Dual-Channel Double-Buffered Converter Register Controller

This block sits behind the serial receiver of a two-channel 16-bit digital-to-analog converter. It executes decoded command words and holds, for each channel, a staging register and an active register. Only the active register drives the converter. A 2-bit bypass mask and a 2-bit output-state field per channel are also held here.

Two asynchronous pins act on the registers. An active-low load pin moves staged values into the active registers. An active-low clear pin acts on its falling edge: it zeroes every code register and tells the receiver to drop the frame in progress. Both pins pass through two-flop synchronisers.

The power-on code is set by a parameter. It is zero scale by default, or midscale. A software reset command restores that code, and in one of its two forms it also resets the mask and the output states.

Top module: `dac_reg_ctrl`

## Requirements
- R1: Command 000 loads data into the staging register of the addressed channel. It leaves the active register untouched unless the channel's mask bit is 1 or the load pin is low.
- R2: Command 001 copies the staging register of the addressed channel into its active register.
- R3: Command 011 loads both registers of the addressed channel with the data. Command 010 loads the staging register of the addressed channel and then refreshes the active register of every channel from its staging register.
- R4: Address 000 selects channel A, 001 selects channel B and 111 selects both. A word that carries address 010 or 011 changes nothing, and so does command 111.
- R5: The load pin is synchronised through two flops. While it is low and enabled, a channel whose staging register has been written since its last active update copies staging into active.
- R6: Command 110 sets the bypass mask from data[1:0], with bit 0 for A and bit 1 for B. After reset both bits are 0. A channel whose mask bit is 1 updates its active register on every write, whatever the pin state.
- R7: Command 100 writes the mode in data[5:4] to each channel selected by data[1:0]. The modes are 00 normal, 01 1 kOhm to ground, 10 100 kOhm to ground and 11 high impedance. pd_mode_o[1:0] is A and pd_mode_o[3:2] is B. A power-down leaves the active code unchanged, and no other command alters the modes.
- R8: A channel that returns to normal mode while the pin is high keeps the active code it held before power-down. If the pin is enabled and low, the channel loads its staging value.
- R9: A synchronised falling edge on the clear pin drives abort_o high for exactly one cycle, and in the next cycle every staging and active register is zero. While the clear pin is low, load-pin activity is ignored. The pin stays disabled after the clear pin rises, until a command word is received.
- R10: After rst_ni both active codes equal the power-on code: 0x8000 when MID_SCALE is 1, 0 otherwise. Both modes are 00 and the mask is 00.
- R11: Command 101 with data[0]=0 restores both code registers of both channels to the power-on code and keeps the mask and the modes. With data[0]=1 it also clears the mask and the modes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous power-on reset |
| word_valid_i | input | 1 | One-cycle strobe for a complete command word |
| cmd_i | input | 3 | Command field of the word |
| addr_i | input | 3 | Channel address field of the word |
| data_i | input | DW | Data field of the word |
| ldac_ni | input | 1 | Asynchronous active-low load pin |
| clr_ni | input | 1 | Asynchronous active-low clear pin, falling-edge triggered |
| dac_code_o | output | NCH*DW | Active codes, channel A in the low DW bits |
| pd_mode_o | output | 2*NCH | Output state per channel, channel A in bits [1:0] |
| abort_o | output | 1 | One-cycle request to the receiver to drop the current frame |

## Verification
Every command is tried first with the load pin held high, so that staging-only writes can be told apart from writes that update the active register. The pin is then pulsed, with the mask bit set on one channel and clear on the other, which separates channels under pin control from channels that bypass it. Power-down and wake-up are tried with a staging value that differs from the active code, so a wake that reloads staging cannot pass for one that keeps the active code. The clear pin is exercised with a word written while it is still low, and then with a load pulse after it rises. The two software reset forms are compared through the mask and mode state that survives each of them.

// File: rtl/dac_ctrl_pkg.sv
package dac_ctrl_pkg;
  typedef enum logic [2:0] {
    CMD_WR_IN      = 3'b000,
    CMD_UPD        = 3'b001,
    CMD_WR_UPD_ALL = 3'b010,
    CMD_WR_UPD     = 3'b011,
    CMD_PWR        = 3'b100,
    CMD_SW_RST     = 3'b101,
    CMD_MASK       = 3'b110,
    CMD_NOP        = 3'b111
  } cmd_e;

  typedef struct packed {
    logic       wr;
    logic       upd;
    logic       pd_wr;
    logic [1:0] pd_mode;
    logic       mask_wr;
    logic       mask_val;
    logic       rst_codes;
    logic       rst_all;
  } ch_op_t;
endpackage

// File: rtl/dac_pin_sync.sv
module dac_pin_sync #(
  parameter int N      = 2,
  parameter int STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] d_i,
  output logic [N-1:0] q_o
);
  for (genvar i = 0; i < N; i++) begin : g_bit
    logic [STAGES-1:0] sr_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) sr_q <= '1;
      else         sr_q <= {sr_q[STAGES-2:0], d_i[i]};
    end
    assign q_o[i] = sr_q[STAGES-1];
  end
endmodule

// File: rtl/dac_cmd_decode.sv
module dac_cmd_decode
  import dac_ctrl_pkg::*;
#(
  parameter int NCH = 2
) (
  input  logic               valid_i,
  input  logic [2:0]         cmd_i,
  input  logic [2:0]         addr_i,
  input  logic [5:0]         data_i,
  output ch_op_t [NCH-1:0]   ops_o
);
  logic [NCH-1:0] sel;

  always_comb begin
    for (int i = 0; i < NCH; i++) sel[i] = (addr_i == 3'b111) || (addr_i == 3'(i));
  end

  always_comb begin
    for (int i = 0; i < NCH; i++) begin
      ops_o[i] = '0;
      if (valid_i) begin
        unique case (cmd_e'(cmd_i))
          CMD_WR_IN:      ops_o[i].wr = sel[i];
          CMD_UPD:        ops_o[i].upd = sel[i];
          CMD_WR_UPD_ALL: begin
            ops_o[i].wr  = sel[i];
            ops_o[i].upd = |sel;
          end
          CMD_WR_UPD: begin
            ops_o[i].wr  = sel[i];
            ops_o[i].upd = sel[i];
          end
          CMD_PWR: begin
            ops_o[i].pd_wr   = data_i[i];
            ops_o[i].pd_mode = data_i[5:4];
          end
          CMD_SW_RST: begin
            ops_o[i].rst_codes = 1'b1;
            ops_o[i].rst_all   = data_i[0];
          end
          CMD_MASK: begin
            ops_o[i].mask_wr  = 1'b1;
            ops_o[i].mask_val = data_i[i];
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/dac_channel.sv
module dac_channel
  import dac_ctrl_pkg::*;
#(
  parameter int            DW       = 16,
  parameter logic [DW-1:0] RST_CODE = '0
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  ch_op_t        op_i,
  input  logic [DW-1:0] data_i,
  input  logic          clr_i,
  input  logic          ldac_en_i,
  output logic [DW-1:0] code_o,
  output logic [1:0]    pd_o
);
  logic [DW-1:0] in_q, dac_q, in_nxt;
  logic          dirty_q, mask_q, wake, upd_now;
  logic [1:0]    pd_q;

  assign in_nxt  = op_i.wr ? data_i : in_q;
  assign wake    = op_i.pd_wr && (op_i.pd_mode == 2'b00) && (pd_q != 2'b00) && ldac_en_i;
  // explicit update, masked write, pin with pending data, or wake with pin low
  assign upd_now = op_i.upd | (op_i.wr & mask_q) | (ldac_en_i & (dirty_q | op_i.wr)) | wake;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      in_q    <= RST_CODE;
      dac_q   <= RST_CODE;
      dirty_q <= 1'b0;
      pd_q    <= 2'b00;
      mask_q  <= 1'b0;
    end else if (clr_i) begin
      in_q    <= '0;
      dac_q   <= '0;
      dirty_q <= 1'b0;
    end else if (op_i.rst_codes) begin
      in_q    <= RST_CODE;
      dac_q   <= RST_CODE;
      dirty_q <= 1'b0;
      if (op_i.rst_all) begin
        pd_q   <= 2'b00;
        mask_q <= 1'b0;
      end
    end else begin
      in_q    <= in_nxt;
      if (upd_now) dac_q <= in_nxt;
      dirty_q <= upd_now ? 1'b0 : (dirty_q | op_i.wr);
      if (op_i.pd_wr)   pd_q   <= op_i.pd_mode;
      if (op_i.mask_wr) mask_q <= op_i.mask_val;
    end
  end

  assign code_o = dac_q;
  assign pd_o   = pd_q;
endmodule

// File: rtl/dac_reg_ctrl.sv
module dac_reg_ctrl
  import dac_ctrl_pkg::*;
#(
  parameter int NCH       = 2,
  parameter int DW        = 16,
  parameter bit MID_SCALE = 1'b0
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               word_valid_i,
  input  logic [2:0]         cmd_i,
  input  logic [2:0]         addr_i,
  input  logic [DW-1:0]      data_i,
  input  logic               ldac_ni,
  input  logic               clr_ni,
  output logic [NCH*DW-1:0]  dac_code_o,
  output logic [2*NCH-1:0]   pd_mode_o,
  output logic               abort_o
);
  localparam logic [DW-1:0] RST_CODE = MID_SCALE ? {1'b1, {(DW-1){1'b0}}} : '0;

  logic [1:0]       pins_s;
  logic             ldac_s, clr_s, clr_prev_q, clr_fall, clear_mode_q, ldac_en;
  ch_op_t [NCH-1:0] ops;

  dac_pin_sync #(.N(2), .STAGES(2)) i_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({clr_ni, ldac_ni}),
    .q_o   (pins_s)
  );
  assign ldac_s = pins_s[0];
  assign clr_s  = pins_s[1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      clr_prev_q   <= 1'b1;
      clear_mode_q <= 1'b0;
    end else begin
      clr_prev_q <= clr_s;
      if (clr_fall)          clear_mode_q <= 1'b1;
      else if (word_valid_i) clear_mode_q <= 1'b0;
    end
  end

  assign clr_fall = clr_prev_q & ~clr_s;
  assign abort_o  = clr_fall;
  assign ldac_en  = ~ldac_s & clr_s & ~clear_mode_q;

  dac_cmd_decode #(.NCH(NCH)) i_dec (
    .valid_i(word_valid_i),
    .cmd_i  (cmd_i),
    .addr_i (addr_i),
    .data_i (data_i[5:0]),
    .ops_o  (ops)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    dac_channel #(.DW(DW), .RST_CODE(RST_CODE)) i_ch (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .op_i     (ops[c]),
      .data_i   (data_i),
      .clr_i    (clr_fall),
      .ldac_en_i(ldac_en),
      .code_o   (dac_code_o[c*DW +: DW]),
      .pd_o     (pd_mode_o[2*c +: 2])
    );
  end
endmodule

// File: rtl/dac_reg_ctrl_chk.sv
module dac_reg_ctrl_chk #(
  parameter int NCH = 2,
  parameter int DW  = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              word_valid_i,
  input logic [2:0]        cmd_i,
  input logic [NCH*DW-1:0] dac_code_o,
  input logic [2*NCH-1:0]  pd_mode_o,
  input logic              abort_o
);
  p_abort_pulse_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    abort_o |=> !abort_o);

  p_clear_zero_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    abort_o |=> (dac_code_o == '0));

  p_pd_idle_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !word_valid_i |=> $stable(pd_mode_o));

  p_pd_other_cmd_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (word_valid_i && (cmd_i != 3'b100) && (cmd_i != 3'b101)) |=> $stable(pd_mode_o));
endmodule

bind dac_reg_ctrl dac_reg_ctrl_chk #(.NCH(NCH), .DW(DW)) i_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .word_valid_i(word_valid_i),
  .cmd_i       (cmd_i),
  .dac_code_o  (dac_code_o),
  .pd_mode_o   (pd_mode_o),
  .abort_o     (abort_o)
);

// File: tb/test_dac_reg_ctrl.sv
module test_dac_reg_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        word_valid = 1'b0;
  logic [2:0]  cmd = '0, addr = '0;
  logic [15:0] data = '0;
  logic        ldac_n = 1'b1, clr_n = 1'b1;
  logic [31:0] code;
  logic [3:0]  pd;
  logic        abort;

  int checks = 0, errors = 0, abort_cnt = 0;
  bit done = 1'b0;

  typedef struct {
    logic [31:0] code;
    logic [3:0]  pd;
    string       tag;
  } exp_t;
  exp_t sb_q[$];

  always #5 clk = ~clk;

  dac_reg_ctrl #(.NCH(2), .DW(16), .MID_SCALE(1'b1)) i_dac_reg_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .word_valid_i(word_valid), .cmd_i(cmd),
    .addr_i(addr), .data_i(data), .ldac_ni(ldac_n), .clr_ni(clr_n),
    .dac_code_o(code), .pd_mode_o(pd), .abort_o(abort)
  );

  always @(posedge clk) if (abort) abort_cnt++;

  // monitor: compare pending expectations away from the active edge
  always @(negedge clk) begin
    while (sb_q.size() > 0) begin
      exp_t e;
      e = sb_q.pop_front();
      checks++;
      if (code !== e.code || pd !== e.pd) begin
        errors++;
        $display("FAIL %s: code=%h pd=%b expected code=%h pd=%b", e.tag, code, pd, e.code, e.pd);
      end
    end
  end

  task automatic expect_st(input logic [31:0] c, input logic [3:0] p, input string tag);
    sb_q.push_back('{code: c, pd: p, tag: tag});
    @(negedge clk);
  endtask

  task automatic send(input logic [2:0] c, input logic [2:0] a, input logic [15:0] d);
    @(negedge clk);
    word_valid = 1'b1; cmd = c; addr = a; data = d;
    @(negedge clk);
    word_valid = 1'b0;
    @(negedge clk);
  endtask

  task automatic pulse_ldac();
    @(negedge clk); ldac_n = 1'b0;
    repeat (4) @(negedge clk);
    ldac_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run did not complete");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    expect_st({16'h8000, 16'h8000}, 4'b0000, "R10 power-on midscale");

    send(3'b000, 3'b000, 16'h1234);
    expect_st({16'h8000, 16'h8000}, 4'b0000, "R1 staging write only");
    send(3'b001, 3'b000, 16'h0000);
    expect_st({16'h8000, 16'h1234}, 4'b0000, "R2 update A");
    send(3'b011, 3'b001, 16'h5555);
    expect_st({16'h5555, 16'h1234}, 4'b0000, "R3 write+update B");
    send(3'b000, 3'b001, 16'h7777);
    expect_st({16'h5555, 16'h1234}, 4'b0000, "R1 staging write B");
    send(3'b000, 3'b000, 16'h1111);
    send(3'b010, 3'b000, 16'h2222);
    expect_st({16'h7777, 16'h2222}, 4'b0000, "R3 write A update all");

    send(3'b000, 3'b010, 16'h9999);
    send(3'b001, 3'b111, 16'h0000);
    expect_st({16'h7777, 16'h2222}, 4'b0000, "R4 reserved address ignored");
    send(3'b111, 3'b000, 16'hFFFF);
    send(3'b001, 3'b000, 16'h0000);
    expect_st({16'h7777, 16'h2222}, 4'b0000, "R4 reserved command ignored");

    send(3'b000, 3'b000, 16'h3333);
    expect_st({16'h7777, 16'h2222}, 4'b0000, "R5 before pin");
    pulse_ldac();
    expect_st({16'h7777, 16'h3333}, 4'b0000, "R5 pin loads pending A");

    send(3'b110, 3'b000, 16'h0002);
    send(3'b000, 3'b001, 16'h4444);
    expect_st({16'h4444, 16'h3333}, 4'b0000, "R6 masked B updates on write");
    send(3'b000, 3'b000, 16'h5151);
    expect_st({16'h4444, 16'h3333}, 4'b0000, "R6 unmasked A waits for pin");
    pulse_ldac();
    expect_st({16'h4444, 16'h5151}, 4'b0000, "R5 pin after mask");

    send(3'b100, 3'b000, 16'h0021);
    expect_st({16'h4444, 16'h5151}, 4'b0010, "R7 A to 100k, code kept");
    send(3'b000, 3'b000, 16'h6000);
    send(3'b100, 3'b000, 16'h0001);
    expect_st({16'h4444, 16'h5151}, 4'b0000, "R8 wake with pin high keeps code");
    pulse_ldac();
    expect_st({16'h4444, 16'h6000}, 4'b0000, "R5 pin after wake");

    send(3'b000, 3'b001, 16'h1212);
    expect_st({16'h1212, 16'h6000}, 4'b0000, "R6 masked B");
    abort_cnt = 0;
    @(negedge clk); clr_n = 1'b0;
    repeat (5) @(negedge clk);
    expect_st(32'h0, 4'b0000, "R9 clear zeroes codes");
    checks++;
    if (abort_cnt != 1) begin
      errors++;
      $display("FAIL R9 abort pulses: got %0d expected 1", abort_cnt);
    end
    send(3'b000, 3'b000, 16'h0ABC);
    pulse_ldac();
    expect_st(32'h0, 4'b0000, "R9 pin ignored while clear low");
    @(negedge clk); clr_n = 1'b1;
    repeat (4) @(negedge clk);
    pulse_ldac();
    expect_st({16'h0000, 16'h0ABC}, 4'b0000, "R9 pin restored after write");

    send(3'b100, 3'b000, 16'h0012);
    expect_st({16'h0000, 16'h0ABC}, 4'b0100, "R7 B to 1k");
    send(3'b101, 3'b000, 16'h0000);
    expect_st({16'h8000, 16'h8000}, 4'b0100, "R11 code-only reset");
    send(3'b000, 3'b001, 16'h0001);
    expect_st({16'h0001, 16'h8000}, 4'b0100, "R11 mask kept");
    send(3'b101, 3'b000, 16'h0001);
    expect_st({16'h8000, 16'h8000}, 4'b0000, "R11 full reset");
    send(3'b000, 3'b001, 16'h0002);
    expect_st({16'h8000, 16'h8000}, 4'b0000, "R11 mask cleared");

    repeat (2) @(negedge clk);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule